// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Queue

This block turns an asynchronous serial line into bytes. A tick that pulses at sixteen times the bit rate paces it. A six-bit format input sets the character shape: the number of data bits, whether a parity bit is present and how it is judged, and the stop length. Each finished character goes into a receive queue with its own three error flags (parity, framing, break). The flags always travel with the byte they belong to.

A reader takes bytes from the head of the queue one at a time. A line status word describes the byte at the head and the state of the queue as a whole. Two flags go to an interrupt unit outside this block:
- a level flag, set when the queue holds at least a chosen number of bytes;
- a stall flag, set when waiting bytes have sat untouched for four character times.

The queue can be switched off. It then acts as a single holding register.

Top module: `serial_rx_core`

## Requirements
- R1: While idle, the receiver waits for a tick on which the line is low. It confirms the start bit on the eighth tick after that, at mid-bit. If the line has returned high by then, nothing is received. Data bits are sampled every 16 ticks after that point, least significant bit first.
- R2: `fmt_i[1:0]` sets the data width: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The received byte is right-aligned and its unused upper bits read as zero.
- R3: `fmt_i[3]` enables a parity bit after the data bits. `fmt_i[5:4]` sets its rule: 0 is odd, 1 is even, 2 requires a 1 and 3 requires a 0. A mismatch sets that byte's parity flag, which appears on `lsr_o[2]`.
- R4: If the first stop position samples low, the byte's framing flag is set (`lsr_o[3]`). The receiver then waits for the line to go high before it looks for a new start bit.
- R5: A frame whose start, data, parity and stop samples are all low is a break. It is queued as exactly one byte of value 0x00 with the break flag (`lsr_o[4]`) and the framing flag set, and its parity flag clear. No further byte is taken until the line returns high.
- R6: `lsr_o` has the following bits:
  - bit 0: the queue is not empty;
  - bits 4:2: the flags of the byte at the head;
  - bit 7: some queued byte still carries a flag;
  - bits 6:5: always zero.

  `rd_data_o` shows the head byte. A one-cycle `rd_en_i` removes that byte.
- R7: A status read clears the overrun bit. A status read is either a `rd_en_i` pulse or an `lsr_rd_i` pulse. An `lsr_rd_i` pulse also clears the flags held by the head byte, but the byte itself stays queued.
- R8: If a byte completes while the queue is full, the byte is dropped and `lsr_o[1]` (overrun) is set.
- R9: `thr_sel_i` sets the level threshold: 0 means 1 byte, 1 means 4, 2 means 8 and 3 means 14. `data_avail_o` is high whenever the queue level is at or above the threshold.
- R10: When `fifo_en_i` is low, the queue holds one byte and the threshold is 1. Any change of `fifo_en_i` empties the queue.
- R11: A `fifo_clr_i` pulse empties the queue, including every stored error flag.
- R12: `char_tmo_o` rises when the queue is non-empty and no byte has arrived or been read for four character times. A character time is 16 ticks for each start, data and parity bit, plus 16 ticks for one stop bit, 32 ticks for two stop bits, or 24 ticks when two stop bits are chosen with 5 data bits. A read clears `char_tmo_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_i | input | 1 | Serial line, idle high |
| fmt_i | input | 6 | Character format (width, stop length, parity enable, parity rule) |
| fifo_en_i | input | 1 | 1: full queue, 0: single holding register |
| thr_sel_i | input | 2 | Level threshold select |
| fifo_clr_i | input | 1 | Pulse to empty the queue |
| rd_en_i | input | 1 | Pulse to take the head byte (also a status read) |
| lsr_rd_i | input | 1 | Pulse marking a line status read |
| rd_data_o | output | 8 | Head byte of the queue |
| lsr_o | output | 8 | Line status word |
| data_avail_o | output | 1 | Queue level at or above threshold |
| char_tmo_o | output | 1 | Stall timeout flag |

## Verification
The hardest condition to reach from the ports is a full queue whose head and tail bytes carry different flags. Reaching it takes sixteen complete frames on the line, then a seventeenth that must be dropped. The bench uses one serial-driving task that can corrupt the parity bit or the stop bit of any frame on request. It builds mixed queues from that task, then drains them, checking byte order, the per-byte flags and the moment the summary bit clears. The stall timer is tested by polling for the instant a byte lands and sampling just before and just after the four-character window. This is done both for a normal format and for the 1.5-stop format.

// File: rtl/rxs_pkg.sv
// Shared types and format helpers for the serial receiver.
// Assumes format bits: [1:0] width, [2] long stop, [3] parity on, [5:4] parity rule.
package rxs_pkg;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_START,
        RS_DATA,
        RS_PAR,
        RS_STOP,
        RS_WAITHI
    } rx_state_t;

    typedef struct packed {
        logic brk;
        logic fe;
        logic pe;
    } rx_err_t;

    // Number of data bits for a width code.
    function automatic logic [3:0] word_bits(input logic [1:0] sel);
        return 4'd5 + {2'b00, sel};
    endfunction

    // Queue level that raises the data-available flag.
    function automatic logic [4:0] thresh_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    // Four character times, in 16x ticks, for a format word.
    function automatic logic [11:0] stall_ticks(input logic [5:0] fmt);
        logic [11:0] ch;
        ch = 12'd16 * (12'd1 + 12'(word_bits(fmt[1:0])) + 12'(fmt[3]));
        if (!fmt[2])               ch = ch + 12'd16;
        else if (fmt[1:0] == 2'd0) ch = ch + 12'd24;
        else                       ch = ch + 12'd32;
        return ch << 2;
    endfunction

endpackage

// File: rtl/rxs_deframer.sv
// Character deframer: finds the start bit, samples bits at their centres,
// and emits one byte with its error flags per frame.
// Assumes tick_i pulses for one cycle at 16x the bit rate and rx_i is synchronised.
module rxs_deframer
    import rxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       rx_i,
    input  logic [5:0] fmt_i,
    output logic       push_o,
    output logic [7:0] data_o,
    output rx_err_t    err_o
);

    rx_state_t   state;
    logic [3:0]  tcnt;
    logic [2:0]  bidx;
    logic [7:0]  shreg;
    logic        par_q;
    logic        zero_q;

    logic [3:0]  wl;
    logic [7:0]  aligned;
    logic        ones;
    logic        par_bad;

    // Align the shifted data and judge the parity bit.
    always_comb begin
        wl      = word_bits(fmt_i[1:0]);
        aligned = shreg >> (4'd8 - wl);
        ones    = (^aligned) ^ par_q;
        case (fmt_i[5:4])
            2'd0:    par_bad = ~ones;
            2'd1:    par_bad = ones;
            2'd2:    par_bad = ~par_q;
            default: par_bad = par_q;
        endcase
    end

    // Frame state machine, advanced on each 16x tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RS_IDLE;
            tcnt   <= '0;
            bidx   <= '0;
            shreg  <= '0;
            par_q  <= 1'b0;
            zero_q <= 1'b0;
            push_o <= 1'b0;
            data_o <= '0;
            err_o  <= '0;
        end else begin
            push_o <= 1'b0;
            if (tick_i) begin
                case (state)
                    RS_IDLE: begin
                        if (!rx_i) begin
                            state <= RS_START;
                            tcnt  <= '0;
                        end
                    end
                    RS_START: begin
                        if (tcnt == 4'd7) begin
                            tcnt   <= '0;
                            bidx   <= '0;
                            zero_q <= 1'b1;
                            state  <= rx_i ? RS_IDLE : RS_DATA;
                        end else begin
                            tcnt <= tcnt + 4'd1;
                        end
                    end
                    RS_DATA: begin
                        if (tcnt == 4'd15) begin
                            tcnt   <= '0;
                            shreg  <= {rx_i, shreg[7:1]};
                            zero_q <= zero_q & ~rx_i;
                            if (bidx == 3'(wl - 4'd1))
                                state <= fmt_i[3] ? RS_PAR : RS_STOP;
                            else
                                bidx <= bidx + 3'd1;
                        end else begin
                            tcnt <= tcnt + 4'd1;
                        end
                    end
                    RS_PAR: begin
                        if (tcnt == 4'd15) begin
                            tcnt   <= '0;
                            par_q  <= rx_i;
                            zero_q <= zero_q & ~rx_i;
                            state  <= RS_STOP;
                        end else begin
                            tcnt <= tcnt + 4'd1;
                        end
                    end
                    RS_STOP: begin
                        if (tcnt == 4'd15) begin
                            tcnt      <= '0;
                            push_o    <= 1'b1;
                            data_o    <= aligned;
                            err_o.brk <= zero_q & ~rx_i;
                            err_o.fe  <= ~rx_i;
                            err_o.pe  <= fmt_i[3] & par_bad & ~(zero_q & ~rx_i);
                            state     <= rx_i ? RS_IDLE : RS_WAITHI;
                        end else begin
                            tcnt <= tcnt + 4'd1;
                        end
                    end
                    RS_WAITHI: begin
                        if (rx_i) state <= RS_IDLE;
                    end
                    default: state <= RS_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rxs_store.sv
// Receive queue holding each byte with its own error flags, plus a count
// of queued bytes that still carry a flag.
// Assumes push_i and pop_i are single-cycle; clr_i wins over everything.
module rxs_store
    import rxs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_i,
    input  logic                   clr_i,
    input  logic                   push_i,
    input  logic [7:0]             wdata_i,
    input  rx_err_t                werr_i,
    input  logic                   pop_i,
    input  logic                   hclr_i,
    output logic [7:0]             head_data_o,
    output rx_err_t                head_err_o,
    output logic [$clog2(DEPTH):0] level_o,
    output logic                   full_o,
    output logic                   err_any_o
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0]   CAP_MAX = (PTR_W + 1)'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DEPTH - 1);

    logic [7:0]       dmem [DEPTH];
    rx_err_t          emem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [PTR_W:0]   err_cnt;
    logic             push_ok, pop_ok, hclr_ok, inc, dec, nonempty;

    // Decide which requests take effect this cycle.
    always_comb begin
        nonempty = (level_o != '0);
        full_o   = (level_o >= (en_i ? CAP_MAX : (PTR_W + 1)'(1)));
        push_ok  = push_i & ~full_o & ~clr_i;
        pop_ok   = pop_i & nonempty & ~clr_i;
        hclr_ok  = hclr_i & ~pop_i & nonempty & ~clr_i;
        inc      = push_ok & (|werr_i);
        dec      = (pop_ok | hclr_ok) & (|emem[rp]);
    end

    // Storage writes: new entries and in-place flag clearing of the head.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            dmem[wp] <= wdata_i;
            emem[wp] <= werr_i;
        end
        if (hclr_ok) emem[rp] <= '0;
    end

    // Pointers, level and flagged-entry count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            wp      <= '0;
            rp      <= '0;
            level_o <= '0;
            err_cnt <= '0;
        end else begin
            if (push_ok) wp <= (wp == PTR_END) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == PTR_END) ? '0 : rp + 1'b1;
            level_o <= level_o + {{PTR_W{1'b0}}, push_ok} - {{PTR_W{1'b0}}, pop_ok};
            err_cnt <= err_cnt + {{PTR_W{1'b0}}, inc} - {{PTR_W{1'b0}}, dec};
        end
    end

    assign head_data_o = nonempty ? dmem[rp] : '0;
    assign head_err_o  = nonempty ? emem[rp] : '0;
    assign err_any_o   = (err_cnt != '0);

endmodule

// File: rtl/rxs_chartmo.sv
// Stall timer: counts 16x ticks while bytes wait untouched and raises a flag
// once the programmed limit is reached.
// Assumes limit_i is non-zero; clear_i marks a read or a flush.
module rxs_chartmo #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          active_i,
    input  logic          restart_i,
    input  logic          clear_i,
    input  logic [CW-1:0] limit_i,
    output logic          flag_o
);

    logic [CW-1:0] cnt;

    // Tick counter with restart on arrivals and clear on reads.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt    <= '0;
            flag_o <= 1'b0;
        end else if (restart_i) begin
            cnt <= '0;
        end else if (tick_i && active_i && !flag_o) begin
            if (cnt == limit_i - 1'b1) begin
                flag_o <= 1'b1;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/serial_rx_core.sv
// Top of the serial receiver: deframer, flagged queue, stall timer, and the
// line status word with a sticky overrun bit.
// Assumes rx_i is already synchronised to clk and tick16_i is one cycle wide.
module serial_rx_core
    import rxs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TMO_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16_i,
    input  logic       rx_i,
    input  logic [5:0] fmt_i,
    input  logic       fifo_en_i,
    input  logic [1:0] thr_sel_i,
    input  logic       fifo_clr_i,
    input  logic       rd_en_i,
    input  logic       lsr_rd_i,
    output logic [7:0] rd_data_o,
    output logic [7:0] lsr_o,
    output logic       data_avail_o,
    output logic       char_tmo_o
);

    localparam int LW = $clog2(DEPTH) + 1;

    logic          fr_push;
    logic [7:0]    fr_data;
    rx_err_t       fr_err;
    rx_err_t       hd_err;
    logic [LW-1:0] st_level;
    logic          st_full, st_err_any;
    logic          en_q, flush, ovr_q;
    logic [LW-1:0] thr;

    rxs_deframer u_defr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick16_i),
        .rx_i   (rx_i),
        .fmt_i  (fmt_i),
        .push_o (fr_push),
        .data_o (fr_data),
        .err_o  (fr_err)
    );

    rxs_store #(.DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (fifo_en_i),
        .clr_i       (flush),
        .push_i      (fr_push),
        .wdata_i     (fr_data),
        .werr_i      (fr_err),
        .pop_i       (rd_en_i),
        .hclr_i      (lsr_rd_i),
        .head_data_o (rd_data_o),
        .head_err_o  (hd_err),
        .level_o     (st_level),
        .full_o      (st_full),
        .err_any_o   (st_err_any)
    );

    rxs_chartmo #(.CW(TMO_W)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick16_i),
        .active_i  (st_level != '0),
        .restart_i (fr_push & ~st_full),
        .clear_i   ((rd_en_i & (st_level != '0)) | flush),
        .limit_i   (TMO_W'(stall_ticks(fmt_i))),
        .flag_o    (char_tmo_o)
    );

    // Flush on a clear command or on any change of the queue mode.
    assign flush = fifo_clr_i | (fifo_en_i != en_q);

    // Track the queue mode so a change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= fifo_en_i;
        else        en_q <= fifo_en_i;
    end

    // Sticky overrun: set by a dropped byte, cleared by either status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ovr_q <= 1'b0;
        else if (fr_push && st_full)   ovr_q <= 1'b1;
        else if (rd_en_i || lsr_rd_i)  ovr_q <= 1'b0;
    end

    // Threshold in use: programmed level with the queue on, one byte with it off.
    assign thr          = fifo_en_i ? LW'(thresh_level(thr_sel_i)) : LW'(1);
    assign data_avail_o = (st_level >= thr);

    assign lsr_o = {st_err_any, 2'b00, hd_err.brk, hd_err.fe, hd_err.pe,
                    ovr_q, (st_level != '0)};

endmodule

// File: rtl/rxs_checker.sv
// Property checker for serial_rx_core, bound onto every instance.
// Assumes it observes the deframer push and the queue full/level internals.
module rxs_checker #(
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rd_en_i,
    input logic                   lsr_rd_i,
    input logic                   fifo_en_i,
    input logic [7:0]             lsr_o,
    input logic                   data_avail_o,
    input logic                   char_tmo_o,
    input logic                   push,
    input logic                   full,
    input logic [$clog2(DEPTH):0] level
);

    a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> lsr_o[1]);

    a_r7_read_clears_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en_i || lsr_rd_i) && !(push && full)) |=> !lsr_o[1]);

    a_r6_summary_covers_head: assert property (@(posedge clk) disable iff (!rst_n)
        (|lsr_o[4:2]) |-> lsr_o[7]);

    a_r5_break_is_framing: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_o[4] |-> lsr_o[3]);

    a_r9_avail_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        data_avail_o |-> lsr_o[0]);

    a_r12_tmo_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        char_tmo_o |-> lsr_o[0]);

    a_r10_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en_i && !$past(fifo_en_i)) |-> (level <= 1));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= ($clog2(DEPTH) + 1)'(DEPTH));

endmodule

bind serial_rx_core rxs_checker #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en_i      (rd_en_i),
    .lsr_rd_i     (lsr_rd_i),
    .fifo_en_i    (fifo_en_i),
    .lsr_o        (lsr_o),
    .data_avail_o (data_avail_o),
    .char_tmo_o   (char_tmo_o),
    .push         (fr_push),
    .full         (st_full),
    .level        (st_level)
);

// File: tb/sim_serial_rx_core.sv
// Directed bench for serial_rx_core: one task per scenario, each self-checking.
module sim_serial_rx_core;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic [1:0] tdiv;
    logic       rx;
    logic [5:0] fmt;
    logic       fifo_en;
    logic [1:0] thr_sel;
    logic       fifo_clr;
    logic       rd_en;
    logic       lsr_rd;
    logic [7:0] rd_data;
    logic [7:0] lsr;
    logic       avail;
    logic       tmo;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    // 16x tick every four clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdiv <= '0;
            tick <= 1'b0;
        end else begin
            tdiv <= tdiv + 2'd1;
            tick <= (tdiv == 2'd3);
        end
    end

    serial_rx_core u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick16_i     (tick),
        .rx_i         (rx),
        .fmt_i        (fmt),
        .fifo_en_i    (fifo_en),
        .thr_sel_i    (thr_sel),
        .fifo_clr_i   (fifo_clr),
        .rd_en_i      (rd_en),
        .lsr_rd_i     (lsr_rd),
        .rd_data_o    (rd_data),
        .lsr_o        (lsr),
        .data_avail_o (avail),
        .char_tmo_o   (tmo)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int nticks);
        @(negedge clk) rx = v;
        repeat (nticks * 4 - 1) @(negedge clk);
    endtask

    task automatic set_fmt(input int wl, input bit pen, input logic [1:0] pty, input bit stop2);
        @(negedge clk) fmt = {pty, pen, stop2, 2'(wl - 5)};
    endtask

    task automatic send(input logic [7:0] d, input int wl, input bit pen,
                        input logic [1:0] pty, input bit bad_par, input bit bad_stop);
        logic [7:0] m;
        logic p;
        m = d & 8'((1 << wl) - 1);
        p = (pty == 2'd0) ? ~^m : (pty == 2'd1) ? ^m : (pty == 2'd2);
        hold(1'b0, 16);
        for (int i = 0; i < wl; i++) hold(m[i], 16);
        if (pen) hold(p ^ bad_par, 16);
        hold(~bad_stop, 16);
        hold(1'b1, 32);
    endtask

    task automatic read_chk(input string req, input logic [7:0] ed, input logic [7:0] el);
        @(negedge clk);
        chk(req, "data", rd_data, ed);
        chk(req, "lsr", lsr, el);
        rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R6", "reset lsr", lsr, 8'h00);
        chk("R9", "reset avail", avail, 0);
        chk("R12", "reset tmo", tmo, 0);
    endtask

    task automatic t_basic();
        set_fmt(8, 0, 0, 0);
        send(8'hA5, 8, 0, 0, 0, 0);
        read_chk("R1", 8'hA5, 8'h01);
        chk("R6", "lsr empty after read", lsr, 8'h00);
    endtask

    task automatic t_glitch();
        hold(1'b0, 4);
        hold(1'b1, 32);
        chk("R1", "short low pulse ignored", lsr[0], 0);
    endtask

    task automatic t_wordlen();
        for (int w = 5; w <= 7; w++) begin
            set_fmt(w, 0, 0, 0);
            send(8'hB6, w, 0, 0, 0, 0);
            read_chk("R2", 8'hB6 & 8'((1 << w) - 1), 8'h01);
        end
    endtask

    task automatic t_parity();
        for (int t = 0; t < 4; t++) begin
            set_fmt(8, 1, 2'(t), 0);
            send(8'h3C, 8, 1, 2'(t), 0, 0);
            send(8'h3C, 8, 1, 2'(t), 1, 0);
            read_chk("R3", 8'h3C, 8'h81);
            read_chk("R3", 8'h3C, 8'h85);
        end
    endtask

    task automatic t_framing();
        set_fmt(8, 0, 0, 0);
        send(8'h5A, 8, 0, 0, 0, 1);
        send(8'h33, 8, 0, 0, 0, 0);
        read_chk("R4", 8'h5A, 8'h89);
        read_chk("R4", 8'h33, 8'h01);
    endtask

    task automatic t_break();
        set_fmt(8, 0, 0, 0);
        hold(1'b0, 12 * 16);
        hold(1'b1, 32);
        read_chk("R5", 8'h00, 8'h99);
        chk("R5", "single break byte", lsr, 8'h00);
    endtask

    task automatic t_lsrclear();
        set_fmt(8, 1, 2'd1, 0);
        send(8'h11, 8, 1, 2'd1, 1, 0);
        @(negedge clk);
        chk("R7", "flag before status read", lsr, 8'h85);
        lsr_rd = 1'b1;
        @(negedge clk) lsr_rd = 1'b0;
        chk("R7", "flags after status read", lsr, 8'h01);
        read_chk("R7", 8'h11, 8'h01);
    endtask

    task automatic t_threshold();
        set_fmt(8, 0, 0, 0);
        @(negedge clk) thr_sel = 2'd1;
        for (int i = 0; i < 3; i++) send(8'(8'h40 + i), 8, 0, 0, 0, 0);
        chk("R9", "3 below 4", avail, 0);
        send(8'h43, 8, 0, 0, 0, 0);
        chk("R9", "4 at 4", avail, 1);
        @(negedge clk) thr_sel = 2'd2;
        @(negedge clk) chk("R9", "4 below 8", avail, 0);
        thr_sel = 2'd0;
        @(negedge clk) chk("R9", "4 above 1", avail, 1);
        for (int i = 0; i < 4; i++) read_chk("R9", 8'(8'h40 + i), 8'h01);
    endtask

    task automatic t_overrun();
        set_fmt(8, 0, 0, 0);
        for (int i = 0; i < 17; i++) send(8'(8'h80 + i), 8, 0, 0, 0, 0);
        @(negedge clk);
        chk("R8", "overrun bit", lsr[1], 1);
        read_chk("R8", 8'h80, 8'h03);
        chk("R7", "read clears overrun", lsr[1], 0);
        for (int i = 1; i < 16; i++) read_chk("R8", 8'(8'h80 + i), 8'h01);
        chk("R8", "17th byte dropped", lsr, 8'h00);
    endtask

    task automatic t_disabled();
        set_fmt(8, 0, 0, 0);
        @(negedge clk) fifo_en = 1'b0;
        thr_sel = 2'd3;
        send(8'h21, 8, 0, 0, 0, 0);
        chk("R10", "threshold forced to 1", avail, 1);
        send(8'h42, 8, 0, 0, 0, 0);
        read_chk("R10", 8'h21, 8'h03);
        chk("R10", "holding register empty", lsr, 8'h00);
        @(negedge clk) fifo_en = 1'b1;
        thr_sel = 2'd0;
        send(8'h77, 8, 0, 0, 0, 0);
        @(negedge clk) fifo_en = 1'b0;
        @(negedge clk) chk("R10", "mode change flushes", lsr[0], 0);
        fifo_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_clear();
        set_fmt(8, 1, 2'd0, 0);
        send(8'h10, 8, 1, 2'd0, 1, 0);
        send(8'h20, 8, 1, 2'd0, 0, 0);
        @(negedge clk) chk("R11", "summary before clear", lsr[7], 1);
        fifo_clr = 1'b1;
        @(negedge clk) fifo_clr = 1'b0;
        chk("R11", "lsr after clear", lsr, 8'h00);
        chk("R11", "avail after clear", avail, 0);
    endtask

    task automatic t_tmo(input int wl, input bit stop2, input int lim);
        int n;
        set_fmt(wl, 0, 0, stop2);
        hold(1'b0, 16);
        hold(1'b1, 16 * wl);
        n = 0;
        while (!lsr[0] && n < 100) begin
            @(negedge clk);
            n++;
        end
        repeat (lim * 4 - 40) @(negedge clk);
        chk("R12", "no timeout before window", tmo, 0);
        repeat (80) @(negedge clk);
        chk("R12", "timeout after window", tmo, 1);
        read_chk("R12", 8'((1 << wl) - 1), 8'h01);
        chk("R12", "read clears timeout", tmo, 0);
    endtask

    initial begin
        rst_n = 1'b0; rx = 1'b1; fmt = 6'h03; fifo_en = 1'b1; thr_sel = 2'd0;
        fifo_clr = 1'b0; rd_en = 1'b0; lsr_rd = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_glitch();
        t_wordlen();
        t_parity();
        t_framing();
        t_break();
        t_lsrclear();
        t_threshold();
        t_overrun();
        t_disabled();
        t_clear();
        t_tmo(8, 1'b0, 640);
        t_tmo(5, 1'b1, 480);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule